// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the power state of a small microcontroller core between running, idle and power-down. It has two low-power states. Software requests them by setting one of two request bits through a write strobe. The controller turns that request into three clock-related enables: one gates the CPU clock, one gates the peripheral clock (RAM, timer/counters, serial port and interrupt logic), and one switches the oscillator. It also drives a strobe that reinitialises the special function registers, and a signal that blocks internal RAM access.

The two low-power states leave in different ways. Idle ends on a pending enabled interrupt or on a hardware reset. Power-down ends only on a hardware reset. When a hardware reset ends idle, the core keeps running for a fixed number of machine cycles before the internal reset sequence takes over. During that stretch RAM access is blocked, but port access is not. When a hardware reset ends power-down, the oscillator is switched back on. The register reset is then held until the oscillator reports that it is stable. RAM is never cleared by any reset path. The clock input is modelled as a free-running reference, and the oscillator enable reports the state the real oscillator should be in.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `por_n` is released, `mode_o` is 0 (run), `cpu_clk_en`, `periph_clk_en` and `osc_en` are 1, `sfr_rst` and `ram_inhibit` are 0, and `req_o` is 0. Mode codes are: 0 run, 1 idle, 2 power-down, 3 reset window, 4 register reset, 5 oscillator wait.
- R2: A write in run mode with `wr_idle`=1 and `wr_pd`=0 sets `req_o`=2'b01 at the next edge and enters idle at the edge after that. In idle, `cpu_clk_en`=0 while `periph_clk_en` and `osc_en` stay 1.
- R3: In idle, a pending interrupt with no hardware reset returns to run at the next edge and clears `req_o` to 0.
- R4: In idle, `hw_rst` (which wins over a simultaneous interrupt) enters the reset window for exactly CYC_CLKS*WIN_CYCLES clocks, even if `hw_rst` falls meanwhile. During the window `ram_inhibit`=1, `sfr_rst`=0, and both clock enables are 1. The window is followed by register reset (mode 4).
- R5: A write with `wr_pd`=1 enters power-down (mode 2) two edges later, with all three enables at 0. Interrupts have no effect there.
- R6: In power-down, `hw_rst` moves to oscillator wait (mode 5) at the next edge. Oscillator wait has `osc_en`=1, `sfr_rst`=1 and `cpu_clk_en`=0, and it persists while `osc_stable` is 0.
- R7: Oscillator wait moves to register reset at the edge after `osc_stable` is 1. Register reset holds `sfr_rst`=1 while `hw_rst` is 1, and returns to run at the edge after `hw_rst` is 0.
- R8: `hw_rst` in run mode enters register reset at the next edge and clears `req_o`. It overrides a write in the same cycle.
- R9: When both request bits are set in one write, `req_o` becomes 2'b11 and power-down is entered, not idle.
- R10: Writes made outside run mode leave `req_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator reference clock |
| por_n | input | 1 | Power-on reset of the controller, active low |
| wr_en | input | 1 | Software write strobe for the request bits |
| wr_idle | input | 1 | Idle request bit of the write |
| wr_pd | input | 1 | Power-down request bit of the write |
| irq_pend | input | 1 | An enabled interrupt is pending |
| hw_rst | input | 1 | Hardware reset pin, active high |
| osc_stable | input | 1 | Oscillator has restarted and is stable |
| cpu_clk_en | output | 1 | CPU clock-gate enable |
| periph_clk_en | output | 1 | Peripheral/RAM/interrupt clock-gate enable |
| osc_en | output | 1 | Oscillator enable |
| sfr_rst | output | 1 | Special function register reset strobe |
| ram_inhibit | output | 1 | Internal RAM access block |
| mode_o | output | 3 | Current mode code (see R1) |
| req_o | output | 2 | Request bits {power-down, idle} |

## Verification
The bench builds the block with CYC_CLKS=3 and WIN_CYCLES=2. This gives a six-clock reset window, short enough to count clock by clock and compare with the product computed in the bench. The small configuration lets the bench sweep all four request-bit combinations from run mode and follow each resulting state through its exit. It also covers reset held through and released during the window, an interrupt that coincides with reset in idle, and several oscillator-wait lengths.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    PM_RUN     = 3'd0,
    PM_IDLE    = 3'd1,
    PM_PDOWN   = 3'd2,
    PM_RSTWIN  = 3'd3,
    PM_RESET   = 3'd4,
    PM_OSCWAIT = 3'd5
  } pm_state_e;

  // Length of the post-reset window in oscillator clocks.
  function automatic int unsigned win_clocks(int unsigned cyc, int unsigned ncyc);
    return cyc * ncyc;
  endfunction

  // Bits needed to hold a down-count starting at len-1.
  function automatic int unsigned cnt_bits(int unsigned len);
    return (len < 3) ? 1 : $clog2(len);
  endfunction

endpackage

// File: rtl/pmc_req_reg.sv
module pmc_req_reg (
  input  logic       clk,
  input  logic       por_n,
  input  logic       wr_en,
  input  logic       wr_idle,
  input  logic       wr_pd,
  input  logic       accept,
  input  logic       clr,
  output logic [1:0] req_q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                req_q <= 2'b00;
    else if (clr)              req_q <= 2'b00;
    else if (wr_en && accept)  req_q <= req_q | {wr_pd, wr_idle};
  end
endmodule

// File: rtl/pmc_win_timer.sv
module pmc_win_timer #(
  parameter int unsigned WIN_LEN = 24
) (
  input  logic clk,
  input  logic por_n,
  input  logic load,
  input  logic run_i,
  output logic done_o
);
  import pmc_pkg::*;
  localparam int unsigned W = cnt_bits(WIN_LEN);

  generate
    if (WIN_LEN <= 1) begin : g_single
      assign done_o = 1'b1;
    end else begin : g_count
      localparam logic [W-1:0] LOAD_V = W'(WIN_LEN - 1);
      logic [W-1:0] cnt_q;
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                      cnt_q <= '0;
        else if (load)                   cnt_q <= LOAD_V;
        else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
      assign done_o = (cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic [1:0] req,
  input  logic       irq_pend,
  input  logic       hw_rst,
  input  logic       osc_stable,
  input  logic       win_done,
  output pm_state_e  st_q,
  output logic       win_load,
  output logic       req_clr
);
  pm_state_e nxt;

  always_comb begin
    nxt = st_q;
    unique case (st_q)
      PM_RUN: begin
        if (hw_rst)      nxt = PM_RESET;
        else if (req[1]) nxt = PM_PDOWN;
        else if (req[0]) nxt = PM_IDLE;
      end
      PM_IDLE: begin
        if (hw_rst)        nxt = PM_RSTWIN;
        else if (irq_pend) nxt = PM_RUN;
      end
      PM_RSTWIN:  if (win_done)   nxt = PM_RESET;
      PM_PDOWN:   if (hw_rst)     nxt = PM_OSCWAIT;
      PM_OSCWAIT: if (osc_stable) nxt = PM_RESET;
      PM_RESET:   if (!hw_rst)    nxt = PM_RUN;
      default:    nxt = PM_RUN;
    endcase
  end

  assign win_load = (st_q == PM_IDLE) && (nxt == PM_RSTWIN);
  assign req_clr  = ((nxt == PM_RUN) && (st_q != PM_RUN)) || (nxt == PM_RESET);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) st_q <= PM_RUN;
    else        st_q <= nxt;
  end
endmodule

// File: rtl/pmc_gate_dec.sv
module pmc_gate_dec
  import pmc_pkg::*;
(
  input  pm_state_e st,
  output logic      cpu_en,
  output logic      per_en,
  output logic      osc_on,
  output logic      sfr_rst,
  output logic      ram_inh
);
  always_comb begin
    cpu_en  = 1'b0;
    per_en  = 1'b0;
    osc_on  = 1'b1;
    sfr_rst = 1'b0;
    ram_inh = 1'b0;
    unique case (st)
      PM_RUN:     begin cpu_en = 1'b1; per_en = 1'b1; end
      PM_IDLE:    per_en = 1'b1;
      PM_RSTWIN:  begin cpu_en = 1'b1; per_en = 1'b1; ram_inh = 1'b1; end
      PM_RESET:   begin cpu_en = 1'b1; per_en = 1'b1; sfr_rst = 1'b1; end
      PM_PDOWN:   osc_on = 1'b0;
      PM_OSCWAIT: sfr_rst = 1'b1;
      default:    ;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int unsigned CYC_CLKS   = 12,
  parameter int unsigned WIN_CYCLES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       wr_en,
  input  logic       wr_idle,
  input  logic       wr_pd,
  input  logic       irq_pend,
  input  logic       hw_rst,
  input  logic       osc_stable,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       osc_en,
  output logic       sfr_rst,
  output logic       ram_inhibit,
  output logic [2:0] mode_o,
  output logic [1:0] req_o
);
  import pmc_pkg::*;
  localparam int unsigned WIN_LEN = win_clocks(CYC_CLKS, WIN_CYCLES);

  pm_state_e  st;
  logic [1:0] req_q;
  logic       win_load;
  logic       win_done;
  logic       req_clr;
  logic       in_run;
  logic       in_win;

  assign in_run = (st == PM_RUN);
  assign in_win = (st == PM_RSTWIN);

  pmc_req_reg u_req (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_idle(wr_idle), .wr_pd(wr_pd),
    .accept(in_run), .clr(req_clr), .req_q(req_q)
  );

  pmc_win_timer #(.WIN_LEN(WIN_LEN)) u_win (
    .clk(clk), .por_n(por_n), .load(win_load), .run_i(in_win), .done_o(win_done)
  );

  pmc_fsm u_fsm (
    .clk(clk), .por_n(por_n), .req(req_q), .irq_pend(irq_pend), .hw_rst(hw_rst),
    .osc_stable(osc_stable), .win_done(win_done), .st_q(st),
    .win_load(win_load), .req_clr(req_clr)
  );

  pmc_gate_dec u_dec (
    .st(st), .cpu_en(cpu_clk_en), .per_en(periph_clk_en), .osc_on(osc_en),
    .sfr_rst(sfr_rst), .ram_inh(ram_inhibit)
  );

  assign mode_o = st;
  assign req_o  = req_q;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int unsigned CYC_CLKS   = 12,
  parameter int unsigned WIN_CYCLES = 2
) (
  input logic       clk,
  input logic       por_n,
  input logic       hw_rst,
  input logic       irq_pend,
  input logic       osc_stable,
  input logic [2:0] mode,
  input logic [1:0] req,
  input logic       cpu_en,
  input logic       per_en,
  input logic       osc_en,
  input logic       sfr_rst,
  input logic       ram_inh,
  input logic       win_load,
  input logic       win_done
);
  import pmc_pkg::*;
  localparam int unsigned WIN_LEN = win_clocks(CYC_CLKS, WIN_CYCLES);

  int unsigned win_seen;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 win_seen <= 0;
    else if (mode == PM_RSTWIN) win_seen <= win_seen + 1;
    else                        win_seen <= 0;
  end

  assert_idle_irq_R3: assert property (@(posedge clk) disable iff (!por_n)
    (mode == PM_IDLE && irq_pend && !hw_rst) |=> (mode == PM_RUN && req == 2'b00));

  assert_win_enter_R4: assert property (@(posedge clk) disable iff (!por_n)
    win_load |=> (mode == PM_RSTWIN));

  assert_win_gates_R4: assert property (@(posedge clk) disable iff (!por_n)
    ram_inh |-> (cpu_en && per_en && !sfr_rst));

  assert_win_bound_R4: assert property (@(posedge clk) disable iff (!por_n)
    (mode == PM_RSTWIN) |-> (win_seen < WIN_LEN));

  assert_win_exit_R4: assert property (@(posedge clk) disable iff (!por_n)
    (mode == PM_RSTWIN && win_done) |=> (mode == PM_RESET));

  assert_pd_holds_R5: assert property (@(posedge clk) disable iff (!por_n)
    (mode == PM_PDOWN && !hw_rst) |=> (mode == PM_PDOWN));

  assert_pd_dark_R5: assert property (@(posedge clk) disable iff (!por_n)
    (mode == PM_PDOWN) |-> (!osc_en && !cpu_en && !per_en));

  assert_osc_wait_R6: assert property (@(posedge clk) disable iff (!por_n)
    (mode == PM_OSCWAIT && !osc_stable) |=> (sfr_rst && osc_en && !cpu_en));

  assert_reset_hold_R7: assert property (@(posedge clk) disable iff (!por_n)
    (mode == PM_RESET && hw_rst) |=> sfr_rst);

  assert_run_clear_R10: assert property (@(posedge clk) disable iff (!por_n)
    (mode == PM_RUN && $past(mode) != PM_RUN) |-> (req == 2'b00));

  assert_pd_prio_R9: assert property (@(posedge clk) disable iff (!por_n)
    (mode == PM_RUN && req[1] && !hw_rst) |=> (mode == PM_PDOWN));
endmodule

bind pwr_mode_ctrl pmc_checker #(.CYC_CLKS(CYC_CLKS), .WIN_CYCLES(WIN_CYCLES)) u_chk (
  .clk(clk), .por_n(por_n), .hw_rst(hw_rst), .irq_pend(irq_pend),
  .osc_stable(osc_stable), .mode(mode_o), .req(req_o), .cpu_en(cpu_clk_en),
  .per_en(periph_clk_en), .osc_en(osc_en), .sfr_rst(sfr_rst),
  .ram_inh(ram_inhibit), .win_load(win_load), .win_done(win_done)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int CYC = 3;
  localparam int NWIN = 2;
  localparam int EXP_WIN = CYC * NWIN;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic por_n, wr_en, wr_idle, wr_pd, irq_pend, hw_rst, osc_stable;
  logic cpu_clk_en, periph_clk_en, osc_en, sfr_rst, ram_inhibit;
  logic [2:0] mode_o;
  logic [1:0] req_o;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  pwr_mode_ctrl #(.CYC_CLKS(CYC), .WIN_CYCLES(NWIN)) u_pwr_mode_ctrl (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_idle(wr_idle), .wr_pd(wr_pd),
    .irq_pend(irq_pend), .hw_rst(hw_rst), .osc_stable(osc_stable),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .sfr_rst(sfr_rst), .ram_inhibit(ram_inhibit), .mode_o(mode_o), .req_o(req_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Expected outputs per mode, restated from the requirement text.
  task automatic chk_mode(string tag, int m);
    int cpu, per, osc, sfr, ram;
    cpu = (m == 0 || m == 3 || m == 4) ? 1 : 0;
    per = (m == 0 || m == 1 || m == 3 || m == 4) ? 1 : 0;
    osc = (m == 2) ? 0 : 1;
    sfr = (m == 4 || m == 5) ? 1 : 0;
    ram = (m == 3) ? 1 : 0;
    chk({tag, " mode"}, int'(mode_o), m);
    chk({tag, " cpu_en"}, int'(cpu_clk_en), cpu);
    chk({tag, " per_en"}, int'(periph_clk_en), per);
    chk({tag, " osc_en"}, int'(osc_en), osc);
    chk({tag, " sfr_rst"}, int'(sfr_rst), sfr);
    chk({tag, " ram_inh"}, int'(ram_inhibit), ram);
  endtask

  task automatic write_req(int idle_b, int pd_b);
    wr_en = 1'b1; wr_idle = idle_b[0]; wr_pd = pd_b[0];
    tick();
    wr_en = 1'b0; wr_idle = 1'b0; wr_pd = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; wr_en = 1'b0; wr_idle = 1'b0; wr_pd = 1'b0;
    irq_pend = 1'b0; hw_rst = 1'b0; osc_stable = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk_mode("R1 reset", 0);
    chk("R1 req", int'(req_o), 0);

    // Sweep every request-bit combination from run mode.
    for (int c = 0; c < 4; c++) begin
      int exp_m;
      write_req(c & 1, (c >> 1) & 1);
      chk("R2/R9 req after write", int'(req_o), c);
      tick();
      exp_m = (c == 0) ? 0 : ((c & 2) != 0) ? 2 : 1;
      chk_mode("R2/R5/R9 entry", exp_m);
      if (exp_m == 1) begin
        write_req(0, 1);
        chk("R10 write in idle ignored", int'(req_o), 1);
        chk_mode("R10 still idle", 1);
        irq_pend = 1'b1;
        tick();
        irq_pend = 1'b0;
        chk_mode("R3 irq exit", 0);
        chk("R3 req cleared", int'(req_o), 0);
      end else if (exp_m == 2) begin
        irq_pend = 1'b1;
        repeat (4) tick();
        chk_mode("R5 irq ignored", 2);
        irq_pend = 1'b0;
        osc_stable = 1'b0;
        hw_rst = 1'b1;
        tick();
        chk_mode("R6 osc wait", 5);
        for (int k = 0; k < c; k++) begin
          tick();
          chk_mode("R6 osc still waiting", 5);
        end
        osc_stable = 1'b1;
        tick();
        chk_mode("R7 reset after stable", 4);
        tick();
        chk_mode("R7 reset held", 4);
        hw_rst = 1'b0;
        tick();
        chk_mode("R7 back to run", 0);
        chk("R7 req cleared", int'(req_o), 0);
      end
    end

    // Idle exit by hardware reset: held through, or released during, the window.
    for (int hold = 0; hold < 2; hold++) begin
      int n;
      write_req(1, 0);
      tick();
      chk_mode("R4 idle before reset", 1);
      hw_rst = 1'b1;
      irq_pend = hold[0];
      tick();
      irq_pend = 1'b0;
      if (hold == 0) hw_rst = 1'b0;
      n = 0;
      while (mode_o == 3'd3 && n < 50) begin
        chk_mode("R4 window", 3);
        n++;
        tick();
      end
      chk("R4 window length", n, EXP_WIN);
      chk_mode("R4 after window", 4);
      if (hold == 1) begin
        tick();
        chk_mode("R7 reset held after window", 4);
        hw_rst = 1'b0;
      end
      tick();
      chk_mode("R7 run after window", 0);
      chk("R4 req cleared", int'(req_o), 0);
    end

    // Hardware reset in run overrides a same-cycle write.
    wr_en = 1'b1; wr_idle = 1'b1; wr_pd = 1'b1; hw_rst = 1'b1;
    tick();
    wr_en = 1'b0; wr_idle = 1'b0; wr_pd = 1'b0;
    chk_mode("R8 run reset", 4);
    chk("R8 req cleared", int'(req_o), 0);
    hw_rst = 1'b0;
    tick();
    chk_mode("R8 run again", 0);
    tick();
    chk_mode("R8 stays run", 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule